// File: doc/BRIEF.md
# Wait-State Static RAM Bus Slave

This block sits between a 32-bit synchronous system bus and two banks of external asynchronous static RAM. When the bus selects it, the block samples the transfer: address, size, direction and endianness. It latches the memory address and the bank choice. It then runs the external strobes for the number of clock cycles that the selected bank's strap inputs ask for. While the access runs it holds the bus ready line low, and it raises that line for one cycle to end the transfer.

Each bank has two static straps. A 2-bit cycle code sets the access length to 2, 3, 4 or 5 clocks. A 2-bit width code sets the bank to 8, 16 or 32 bits wide. The transfer size and the two lowest address bits are decoded into four active-low byte-lane write strobes, with the lane order mirrored when the big-endian input is high. Lanes that the bank's width does not reach are never strobed. The block does not split a wide transfer across a narrow bank into several accesses.

The sequencer has four states, named IDLE, LEAD, MID and TAIL:

- IDLE moves to LEAD when the bus select is sampled.
- LEAD moves to MID when the access length is more than 2. Otherwise it moves to TAIL.
- MID stays in MID until the in-access counter reaches the length minus 2, and then moves to TAIL.
- TAIL always returns to IDLE.

Top module: `sram_ws_slave`

## Requirements
- R1: After reset, and whenever the sequencer is in IDLE, the following outputs are all high: chip select, output enable, the four write strobes, both buffer enables and ready.
- R2: A read from a bank with cycle code c (00, 01, 10, 11) holds chip select low for exactly c+2 cycles. These cycles start on the cycle after the select is sampled.
- R3: A write to a bank with cycle code 00 is stretched to 3 cycles. Writes with the other codes last c+2 cycles, as reads do.
- R4: Ready is low in every access cycle except the last. It is high in the last cycle only, and chip select is high on the following cycle.
- R5: Address bit 18 chooses the bank: 0 selects bank 0 and 1 selects bank 1. The chosen bank's straps alone set the length and width, bank_sel shows the chosen bank, and mem_addr carries bus address bits 17:2. Both outputs are held for the whole access.
- R6: The size encoding is 00 byte, 01 halfword, 10 word, and 11 is treated as a word. With big_endian low, a byte strobes lane A[1:0], a halfword strobes lanes 0-1 when A[1]=0 and lanes 2-3 when A[1]=1, and a word strobes all four lanes. Lane n covers data bits 8n+7:8n.
- R7: With big_endian high, a byte strobes lane A[1:0] XOR 3, and the two halfword lane pairs are swapped.
- R8: The bank width code is 00 for 8-bit, 01 for 16-bit, 10 for 32-bit and 11 (reserved) for 32-bit. An 8-bit bank strobes only lane 0 and a 16-bit bank only lanes 0-1. Any other lane the transfer asks for is dropped.
- R9: Write strobes are low only in the middle cycles of a write access, never in its first or last cycle.
- R10: Output enable is low in every cycle of a read access, and it stays high throughout a write access. No write strobe is ever low while output enable is low.
- R11: The memory-side buffer enable is low during a write access and the bus-side buffer enable is low during a read access. The two are never low together.
- R12: The select input is sampled only in IDLE. A select raised during an access changes neither the latched address nor the bank, and does not start a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 19 | Bus address: bit 18 is the bank, bits 17:2 the word address, bits 1:0 the byte offset |
| bus_size | input | 2 | Transfer size code |
| bus_write | input | 1 | High for a write transfer |
| bus_sel | input | 1 | Slave select, sampled in IDLE |
| big_endian | input | 1 | Mirrors the byte-lane order when high |
| bank0_cyc | input | 2 | Bank 0 access-length strap |
| bank0_width | input | 2 | Bank 0 width strap |
| bank1_cyc | input | 2 | Bank 1 access-length strap |
| bank1_width | input | 2 | Bank 1 width strap |
| bus_ready | output | 1 | Low stretches the transfer, high ends it |
| mem_addr | output | 16 | Latched word address to the RAM |
| bank_sel | output | 1 | Latched bank choice |
| mem_cs_n | output | 1 | Shared chip select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_we_n | output | 4 | Per-lane write strobes, active low |
| mem_buf_oe_n | output | 1 | Memory-side data buffer enable, active low |
| bus_buf_oe_n | output | 1 | Bus-side data buffer enable, active low |

## Verification
The bench sweeps every combination of the following for both banks, giving 2048 transfers:

- the four cycle codes and the four width codes,
- both directions,
- the four size codes,
- the four byte offsets,
- both endian settings.

The unused bank is strapped to the complementary codes, so taking the length or width from the wrong bank shows up as a wrong length or lane pattern. The byte and halfword patterns separate the offset decode and the endian mirroring. The width codes separate lane pruning from lane selection. The code-00 writes separate the stretched write length from the read length.

A separate test raises the select with a different bank and address while a long read is running. It shows whether the select is honoured outside IDLE.

// File: rtl/sram_ws_pkg.sv
package sram_ws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_MID  = 2'd2,
        ST_TAIL = 2'd3
    } acc_state_t;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    localparam logic [1:0] WD_8  = 2'b00;
    localparam logic [1:0] WD_16 = 2'b01;

    localparam int LEN_W       = 3;
    localparam int MIN_WR_LEN  = 3;

    // Access length in cycles from the cycle code; writes need a middle cycle.
    function automatic logic [LEN_W-1:0] access_len(input logic [1:0] cyc, input logic wr);
        logic [LEN_W-1:0] n;
        n = {1'b0, cyc} + LEN_W'(2);
        if (wr && (n < LEN_W'(MIN_WR_LEN)))
            n = LEN_W'(MIN_WR_LEN);
        return n;
    endfunction

endpackage

// File: rtl/sram_ws_cfgsel.sv
module sram_ws_cfgsel #(
    parameter int BANK_BITS = 1
) (
    input  logic [(2<<BANK_BITS)-1:0] cyc_all,
    input  logic [(2<<BANK_BITS)-1:0] wid_all,
    input  logic [BANK_BITS-1:0]      bank,
    output logic [1:0]                cyc,
    output logic [1:0]                wid
);
    localparam int NBANK = 1 << BANK_BITS;

    always_comb begin
        cyc = cyc_all[1:0];
        wid = wid_all[1:0];
        for (int b = 1; b < NBANK; b++) begin
            if (bank == BANK_BITS'(b)) begin
                cyc = cyc_all[2*b +: 2];
                wid = wid_all[2*b +: 2];
            end
        end
    end

endmodule

// File: rtl/sram_ws_lanes.sv
module sram_ws_lanes
    import sram_ws_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] alo,
    input  logic       big_end,
    input  logic [1:0] width,
    output logic [3:0] lane_en
);
    for (genvar i = 0; i < 4; i++) begin : g_lane
        localparam logic [1:0] IDX = 2'(i);
        logic hit;
        logic fits;

        // Lane requested by size, offset and byte order
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (IDX == (alo ^ {2{big_end}}));
                SZ_HALF: hit = (IDX[1] == (alo[1] ^ big_end));
                default: hit = 1'b1;
            endcase
        end

        // Lane physically present in a bank of this width
        always_comb begin
            unique case (width)
                WD_8:    fits = (i == 0);
                WD_16:   fits = (i < 2);
                default: fits = 1'b1;
            endcase
        end

        assign lane_en[i] = hit & fits;
    end

endmodule

// File: rtl/sram_ws_seq.sv
module sram_ws_seq
    import sram_ws_pkg::*;
#(
    parameter int CW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          idle,
    output logic          busy,
    output logic          strobe_win,
    output logic          ready
);
    acc_state_t    state;
    acc_state_t    nxt;
    logic [CW-1:0] cnt;

    // State register and in-access counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE)
                cnt <= '0;
            else
                cnt <= cnt + CW'(1);
        end
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_LEAD;
            ST_LEAD: nxt = (len > CW'(2)) ? ST_MID : ST_TAIL;
            ST_MID:  if (cnt == (len - CW'(2))) nxt = ST_TAIL;
            ST_TAIL: nxt = ST_IDLE;
        endcase
    end

    // Per-state outputs
    always_comb begin
        idle       = 1'b0;
        busy       = 1'b1;
        strobe_win = 1'b0;
        ready      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle  = 1'b1;
                busy  = 1'b0;
                ready = 1'b1;
            end
            ST_LEAD: ready = 1'b0;
            ST_MID:  strobe_win = 1'b1;
            ST_TAIL: ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/sram_ws_slave.sv
module sram_ws_slave
    import sram_ws_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW+2:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_sel,
    input  logic              big_endian,
    input  logic [1:0]        bank0_cyc,
    input  logic [1:0]        bank0_width,
    input  logic [1:0]        bank1_cyc,
    input  logic [1:0]        bank1_width,
    output logic              bus_ready,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              bank_sel,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic [3:0]        mem_we_n,
    output logic              mem_buf_oe_n,
    output logic              bus_buf_oe_n
);
    localparam int BANK_POS = MEM_AW + 2;

    logic [1:0]        sel_cyc;
    logic [1:0]        sel_wid;
    logic [3:0]        lane_mask;
    logic              seq_idle;
    logic              seq_busy;
    logic              seq_win;
    logic              seq_ready;
    logic              start;

    logic [MEM_AW-1:0] cap_addr;
    logic              cap_bank;
    logic              cap_wr;
    logic [3:0]        cap_mask;
    logic [LEN_W-1:0]  cap_len;

    sram_ws_cfgsel #(.BANK_BITS(1)) u_cfg (
        .cyc_all (({bank1_cyc, bank0_cyc})),
        .wid_all (({bank1_width, bank0_width})),
        .bank    (bus_addr[BANK_POS]),
        .cyc     (sel_cyc),
        .wid     (sel_wid)
    );

    sram_ws_lanes u_lanes (
        .size    (bus_size),
        .alo     (bus_addr[1:0]),
        .big_end (big_endian),
        .width   (sel_wid),
        .lane_en (lane_mask)
    );

    assign start = bus_sel & seq_idle;

    // Transfer attributes are latched once, when the request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_bank <= 1'b0;
            cap_wr   <= 1'b0;
            cap_mask <= '0;
            cap_len  <= LEN_W'(2);
        end else if (start) begin
            cap_addr <= bus_addr[MEM_AW+1:2];
            cap_bank <= bus_addr[BANK_POS];
            cap_wr   <= bus_write;
            cap_mask <= lane_mask;
            cap_len  <= access_len(sel_cyc, bus_write);
        end
    end

    sram_ws_seq #(.CW(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len        (cap_len),
        .idle       (seq_idle),
        .busy       (seq_busy),
        .strobe_win (seq_win),
        .ready      (seq_ready)
    );

    // External strobes
    always_comb begin
        mem_cs_n     = ~seq_busy;
        mem_oe_n     = ~(seq_busy & ~cap_wr);
        mem_we_n     = ~({4{seq_win & cap_wr}} & cap_mask);
        mem_buf_oe_n = ~(seq_busy & cap_wr);
        bus_buf_oe_n = ~(seq_busy & ~cap_wr);
        bus_ready    = seq_ready;
        mem_addr     = cap_addr;
        bank_sel     = cap_bank;
    end

endmodule

// File: rtl/sram_ws_chk.sv
module sram_ws_chk #(
    parameter int MEM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bank0_width,
    input logic [1:0]        bank1_width,
    input logic              bus_ready,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              bank_sel,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic [3:0]        mem_we_n,
    input logic              mem_buf_oe_n,
    input logic              bus_buf_oe_n
);
    logic [2:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (mem_cs_n)
            run_len <= '0;
        else if (run_len != 3'd7)
            run_len <= run_len + 3'd1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (&mem_we_n && mem_oe_n && mem_buf_oe_n && bus_buf_oe_n && bus_ready)); // R1
    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (run_len < 3'd5)); // R2
    AST_WRITE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && bus_ready && !mem_buf_oe_n) |-> (run_len >= 3'd2)); // R3
    AST_READY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && bus_ready) |=> mem_cs_n); // R4
    AST_NARROW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && ((bank_sel ? bank1_width : bank0_width) == 2'b00)) |-> (&mem_we_n[3:1])); // R8
    AST_WE_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (&mem_we_n)); // R9
    AST_WE_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && bus_ready) |-> (&mem_we_n)); // R9
    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (&mem_we_n)); // R10
    AST_BUF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_buf_oe_n |-> bus_buf_oe_n); // R11
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(bank_sel))); // R12

endmodule

bind sram_ws_slave sram_ws_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank0_width  (bank0_width),
    .bank1_width  (bank1_width),
    .bus_ready    (bus_ready),
    .mem_addr     (mem_addr),
    .bank_sel     (bank_sel),
    .mem_cs_n     (mem_cs_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_buf_oe_n (mem_buf_oe_n),
    .bus_buf_oe_n (bus_buf_oe_n)
);

// File: tb/sim_sram_ws_slave.sv
module sim_sram_ws_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_write = 1'b0;
    logic        bus_sel = 1'b0;
    logic        big_endian = 1'b0;
    logic [1:0]  bank0_cyc = '0;
    logic [1:0]  bank0_width = '0;
    logic [1:0]  bank1_cyc = '0;
    logic [1:0]  bank1_width = '0;
    logic        bus_ready;
    logic [15:0] mem_addr;
    logic        bank_sel;
    logic        mem_cs_n;
    logic        mem_oe_n;
    logic [3:0]  mem_we_n;
    logic        mem_buf_oe_n;
    logic        bus_buf_oe_n;

    int checks = 0;
    int fails  = 0;
    int seed   = 1;
    bit done   = 0;

    always #10 clk = ~clk;

    sram_ws_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_write(bus_write), .bus_sel(bus_sel), .big_endian(big_endian),
        .bank0_cyc(bank0_cyc), .bank0_width(bank0_width),
        .bank1_cyc(bank1_cyc), .bank1_width(bank1_width),
        .bus_ready(bus_ready), .mem_addr(mem_addr), .bank_sel(bank_sel),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_buf_oe_n(mem_buf_oe_n), .bus_buf_oe_n(bus_buf_oe_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input int sz, input int a, input int be, input int wid);
        int idx;
        logic [3:0] m;
        case (sz)
            0: begin idx = (be != 0) ? (a ^ 3) : a; m = 4'(1 << idx); end
            1: begin idx = (a >= 2) ? 2 : 0; if (be != 0) idx = 2 - idx; m = 4'(3 << idx); end
            default: m = 4'hF;
        endcase
        if (wid == 0) m = m & 4'h1;
        else if (wid == 1) m = m & 4'h3;
        return m;
    endfunction

    function automatic bit idle_outs();
        return mem_cs_n && mem_oe_n && (mem_we_n == 4'hF) && mem_buf_oe_n && bus_buf_oe_n && bus_ready;
    endfunction

    task automatic do_xfer(input int bank, input int cyc, input int wid, input int wr,
                           input int sz, input int a, input int be);
        int L;
        int k;
        logic [3:0] m;
        logic [15:0] hi;
        bit ok_rdy, ok_edge, ok_mid, ok_nar, ok_oe, ok_buf, ok_adr;
        logic [3:0] bad_we;
        L = cyc + 2;
        if (wr != 0 && L < 3) L = 3;
        m = exp_mask(sz, a, be, wid);
        seed = seed + 1;
        hi = 16'(seed * 40503 + 7);
        ok_rdy = 1; ok_edge = 1; ok_mid = 1; ok_nar = 1; ok_oe = 1; ok_buf = 1; ok_adr = 1;
        bad_we = 4'hF;
        @(negedge clk);
        bus_addr   = {1'(bank), hi, 2'(a)};
        bus_size   = 2'(sz);
        bus_write  = 1'(wr);
        big_endian = 1'(be);
        bus_sel    = 1'b1;
        @(negedge clk);
        bus_sel  = 1'b0;
        bus_addr = ~bus_addr;
        k = 0;
        while (!mem_cs_n && k < 12) begin
            if (bus_ready != (k == L - 1)) ok_rdy = 0;
            if (k == 0 || k == L - 1 || wr == 0) begin
                if (mem_we_n != 4'hF) begin ok_edge = 0; bad_we = mem_we_n; end
            end else if (mem_we_n != ~m) begin
                ok_mid = 0; bad_we = mem_we_n;
            end
            if (wid == 0 && mem_we_n[3:1] != 3'b111) ok_nar = 0;
            if (wid == 1 && mem_we_n[3:2] != 2'b11) ok_nar = 0;
            if (mem_oe_n != (wr != 0)) ok_oe = 0;
            if (mem_buf_oe_n != (wr == 0) || bus_buf_oe_n != (wr != 0)) ok_buf = 0;
            if (mem_addr != hi || bank_sel != 1'(bank)) ok_adr = 0;
            @(negedge clk);
            k++;
        end
        if (wr != 0 && cyc == 0) chk(k == L, "R3 write length", k, L);
        else chk(k == L, "R2 access length", k, L);
        chk(ok_rdy, "R4 ready pattern", k, L);
        chk(ok_edge, "R9 strobe outside middle", bad_we, 4'hF);
        if (be != 0) chk(ok_mid, "R7 big-endian lanes", bad_we, ~m);
        else chk(ok_mid, "R6 little-endian lanes", bad_we, ~m);
        chk(ok_nar, "R8 width pruning", bad_we, ~m);
        chk(ok_oe, "R10 output enable", wr, wr);
        chk(ok_buf, "R11 buffer enables", wr, wr);
        chk(ok_adr, "R5 bank and address", int'(bank_sel), bank);
        chk(idle_outs(), "R1 idle after access", int'(mem_cs_n), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int k;
        bit ok_hold;
        repeat (3) @(negedge clk);
        chk(idle_outs(), "R1 outputs in reset", int'(mem_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle_outs(), "R1 outputs after reset", int'(mem_cs_n), 1);

        for (int bank = 0; bank < 2; bank++)
            for (int cyc = 0; cyc < 4; cyc++)
                for (int wid = 0; wid < 4; wid++) begin
                    if (bank == 0) begin
                        bank0_cyc = 2'(cyc); bank0_width = 2'(wid);
                        bank1_cyc = 2'(3 - cyc); bank1_width = 2'(3 - wid);
                    end else begin
                        bank1_cyc = 2'(cyc); bank1_width = 2'(wid);
                        bank0_cyc = 2'(3 - cyc); bank0_width = 2'(3 - wid);
                    end
                    for (int wr = 0; wr < 2; wr++)
                        for (int sz = 0; sz < 4; sz++)
                            for (int a = 0; a < 4; a++)
                                for (int be = 0; be < 2; be++)
                                    do_xfer(bank, cyc, wid, wr, sz, a, be);
                end

        // R12: select raised with another bank and address during a 5-cycle read
        bank0_cyc = 2'b11; bank0_width = 2'b10;
        bank1_cyc = 2'b00; bank1_width = 2'b10;
        @(negedge clk);
        bus_addr = {1'b0, 16'h1234, 2'b00};
        bus_write = 1'b0; bus_size = 2'b10; bus_sel = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0;
        k = 0;
        ok_hold = 1;
        while (!mem_cs_n && k < 12) begin
            if (mem_addr != 16'h1234 || bank_sel != 1'b0) ok_hold = 0;
            if (k == 1) begin
                bus_addr = {1'b1, 16'hBEEF, 2'b00};
                bus_sel = 1'b1;
            end
            if (k == 2) bus_sel = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(ok_hold, "R12 address held", int'(mem_addr), 16'h1234);
        chk(k == 5, "R12 length unchanged", k, 5);
        @(negedge clk);
        chk(mem_cs_n == 1'b1, "R12 no second access", int'(mem_cs_n), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule